// File: doc/BRIEF.md
# Frame Alignment Defect Monitor

This block follows the frame-alignment health of a received STS-3 stream. An upstream framer hunts for the framing pattern. Once per frame period it pulses `frame_tick`, and with that pulse it reports two things: whether it currently holds alignment (`in_frame`) and whether the framing bytes of that frame matched (`frame_ok`). From these reports the monitor derives two defects, severely errored framing and loss of frame. It presents them in a read-only status register, next to six other defect flags that neighbouring logic supplies.

The monitor has three alignment states:

- Hunting: both defects are declared.
- Verifying: the severely-errored-framing defect is cleared but loss of frame is still declared. In this state every frame's framing bytes are tested, and loss of frame is cleared only after a programmable run of consecutive clean frames.
- Synchronised: both defects are cleared.

Each change of either defect latches a bit in a clear-on-read interrupt status register and pulls the active-low interrupt pin. A 4-bit threshold register sets the length of the clean run.

The register port is a plain single-cycle read/write port with a combinational read path. Reading the interrupt register clears it on the clock edge that ends the read cycle.

Top module: `sef_lof_monitor`

## Requirements
- R1: After reset the severe-framing defect (SEF) and the loss-of-frame defect (LOF) are both declared, all interrupt status bits are 0, `irq_n` is 1 and the threshold field holds the parameter `RST_THR`.
- R2: In the hunting state (SEF=1, LOF=1), a `frame_tick` with `in_frame`=1 moves the block to SEF=0, LOF=1 and starts the clean-frame count at zero.
- R3: In the SEF=0, LOF=1 state, LOF clears on the tick that completes N consecutive ticks with `in_frame`=1 and `frame_ok`=1. N is the threshold field, and a field value of 0 counts as 1.
- R4: In the SEF=0, LOF=1 state, a tick with `frame_ok`=0 and `in_frame`=1 restarts the clean-frame count at zero, so a full N clean ticks are needed again.
- R5: A tick with `in_frame`=0 in any state returns the block to SEF=1, LOF=1. In the synchronised state `frame_ok` has no effect.
- R6: SEF and LOF change only on clock edges where `frame_tick` is 1.
- R7: Address 0 reads the status register. Bit 0 is `los_in`, bit 1 is SEF, bit 2 is LOF, and bits 7:3 are `aux_defects[4:0]`. Writes to this address have no effect.
- R8: Address 2 holds the threshold in bits 3:0 and is read/write. Bits 7:4 always read 0. Address 3 reads 0.
- R9: Address 1 reads the interrupt status. Bit 1 is set by any SEF change and bit 2 by any LOF change; all other bits read 0. A read with `reg_rd`=1 returns the pending bits and clears them at the end of that cycle.
- R10: `irq_n` is 0 whenever any interrupt status bit is set, and it is 1 again after a read has cleared all of them.
- R11: A defect change that happens in the same cycle as a clearing read of address 1 remains pending after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per frame period |
| in_frame | input | 1 | Framer holds alignment (valid with `frame_tick`) |
| frame_ok | input | 1 | Framing bytes of this frame correct (valid with `frame_tick`) |
| los_in | input | 1 | Loss-of-signal flag shown in status bit 0 |
| aux_defects | input | 5 | Other defect flags shown in status bits 7:3 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt status on address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from `reg_addr`) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The delicate overlap in this block is a clearing read of the interrupt register that falls in the same cycle as a frame tick that changes a defect. If either the clear or the latch wins outright, an event is lost or a stale bit survives.

The bench provokes this overlap by raising `reg_rd` on address 1 together with a `frame_tick` that drops alignment from the synchronised state. Both defects flip on that tick. The bench judges the result against its own model: the data returned by the read must show the old pending bits, and afterwards bits 1 and 2 must both be pending with `irq_n` held low.

The sweep also exercises the clean-run counter against a framing error arriving one frame short of the threshold, for every threshold value.

// File: rtl/sef_lof_pkg.sv
package sef_lof_pkg;

  localparam int THR_W  = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_INT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_THR  = 2'd2;

  // Bit positions inside the status and interrupt registers
  localparam int BIT_SEF = 1;
  localparam int BIT_LOF = 2;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,   // SEF=1 LOF=1
    ST_VERIFY = 2'd1,   // SEF=0 LOF=1
    ST_SYNC   = 2'd2    // SEF=0 LOF=0
  } align_st_e;

  // A zero threshold behaves as one frame
  function automatic logic [THR_W-1:0] eff_thresh(input logic [THR_W-1:0] thr);
    return (thr == '0) ? THR_W'(1) : thr;
  endfunction

  // True when one more clean frame completes the run
  function automatic logic run_done(input logic [THR_W-1:0] cnt,
                                    input logic [THR_W-1:0] thr);
    logic [THR_W:0] nxt;
    nxt = {1'b0, cnt} + (THR_W+1)'(1);
    return nxt >= {1'b0, eff_thresh(thr)};
  endfunction

endpackage

// File: rtl/align_fsm.sv
module align_fsm
  import sef_lof_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             in_frame,
  input  logic             frame_ok,
  input  logic [THR_W-1:0] thresh,
  output logic             sef,
  output logic             lof,
  output logic             sef_chg,
  output logic             lof_chg
);

  align_st_e        st_q, st_d;
  logic [THR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (frame_tick) begin
      unique case (st_q)
        ST_HUNT: begin
          if (in_frame) begin
            st_d  = ST_VERIFY;
            cnt_d = '0;
          end
        end
        ST_VERIFY: begin
          if (!in_frame) begin
            st_d = ST_HUNT;
          end else if (!frame_ok) begin
            cnt_d = '0;
          end else if (run_done(cnt_q, thresh)) begin
            st_d  = ST_SYNC;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + THR_W'(1);
          end
        end
        ST_SYNC: begin
          if (!in_frame) st_d = ST_HUNT;
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign sef     = (st_q == ST_HUNT);
  assign lof     = (st_q != ST_SYNC);
  assign sef_chg = (st_d == ST_HUNT) != (st_q == ST_HUNT);
  assign lof_chg = (st_d != ST_SYNC) != (st_q != ST_SYNC);

endmodule

// File: rtl/defect_irq.sv
module defect_irq #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic             clr,
  output logic [N_SRC-1:0] pend,
  output logic             irq_n
);

  logic [N_SRC-1:0] pend_d;

  // Clear first, then add new events so a same-cycle event survives
  assign pend_d = (clr ? '0 : pend) | evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      irq_n <= 1'b1;
    end else begin
      pend  <= pend_d;
      irq_n <= ~|pend_d;
    end
  end

endmodule

// File: rtl/sef_lof_monitor.sv
module sef_lof_monitor
  import sef_lof_pkg::*;
#(
  parameter logic [3:0] RST_THR = 4'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_tick,
  input  logic        in_frame,
  input  logic        frame_ok,
  input  logic        los_in,
  input  logic [4:0]  aux_defects,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_n
);

  localparam int N_SRC = 2;

  logic [THR_W-1:0] thr_q;
  logic             sef, lof, sef_chg, lof_chg;
  logic [N_SRC-1:0] pend;
  logic             int_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)                              thr_q <= RST_THR;
    else if (reg_wr && reg_addr == ADDR_THR) thr_q <= reg_wdata[THR_W-1:0];
  end

  assign int_clr = reg_rd && (reg_addr == ADDR_INT);

  align_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .in_frame(in_frame),
    .frame_ok(frame_ok), .thresh(thr_q), .sef(sef), .lof(lof),
    .sef_chg(sef_chg), .lof_chg(lof_chg)
  );

  defect_irq #(.N_SRC(N_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt({lof_chg, sef_chg}), .clr(int_clr),
    .pend(pend), .irq_n(irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_STAT: begin
        reg_rdata[0]       = los_in;
        reg_rdata[BIT_SEF] = sef;
        reg_rdata[BIT_LOF] = lof;
        reg_rdata[7:3]     = aux_defects;
      end
      ADDR_INT: begin
        reg_rdata[BIT_SEF] = pend[0];
        reg_rdata[BIT_LOF] = pend[1];
      end
      ADDR_THR: reg_rdata[THR_W-1:0] = thr_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sef_lof_monitor_chk.sv
module sef_lof_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick,
  input logic       in_frame,
  input logic       frame_ok,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       irq_n,
  input logic       sef,
  input logic       lof,
  input logic [1:0] pend
);

  a_r2_hunt_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && in_frame && sef && lof) |=> (!sef && lof));

  a_r3_lof_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof) |-> $past(frame_tick && in_frame && frame_ok && !sef));

  a_r5_align_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !in_frame) |=> (sef && lof));

  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(sef) && $stable(lof)));

  a_r9_sef_change_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sef != $past(sef)) |-> pend[0]);

  a_r9_lof_change_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (lof != $past(lof)) |-> pend[1]);

  a_r8_thr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata[7:4] == 4'd0));

  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == (pend == 2'b00));

  a_r11_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd1 && frame_tick && !in_frame && !sef) |=> pend[0]);

endmodule

bind sef_lof_monitor sef_lof_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .in_frame(in_frame),
  .frame_ok(frame_ok), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq_n(irq_n), .sef(sef), .lof(lof), .pend(pend)
);

// File: tb/sef_lof_monitor_tb.sv
module sef_lof_monitor_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0, in_frame = 1'b0, frame_ok = 1'b0, los_in = 1'b0;
  logic [4:0] aux_defects = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic       m_sef, m_lof;
  int         m_cnt, m_thr;
  logic [7:0] m_ist;

  always #10 clk = ~clk;  // 50 MHz

  sef_lof_monitor #(.RST_THR(4'd4)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .in_frame(in_frame),
    .frame_ok(frame_ok), .los_in(los_in), .aux_defects(aux_defects),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_tick(input logic i, input logic o, input logic clr);
    logic ns, nl;
    int need;
    ns = m_sef; nl = m_lof;
    need = (m_thr == 0) ? 1 : m_thr;
    if (!i) begin ns = 1; nl = 1; end
    else if (m_sef) begin ns = 0; m_cnt = 0; end
    else if (m_lof) begin
      if (!o) m_cnt = 0;
      else if (m_cnt + 1 >= need) begin nl = 0; m_cnt = 0; end
      else m_cnt++;
    end
    if (clr) m_ist = 8'h00;
    if (ns != m_sef) m_ist[1] = 1'b1;
    if (nl != m_lof) m_ist[2] = 1'b1;
    m_sef = ns; m_lof = nl;
  endtask

  task automatic tick(input logic i, input logic o);
    @(negedge clk);
    frame_tick = 1; in_frame = i; frame_ok = o;
    @(negedge clk);
    frame_tick = 0;
    model_tick(i, o, 1'b0);
  endtask

  task automatic check_state(input string tag);
    reg_addr = 2'd0;
    #1;
    chk({tag, " status SEF"}, reg_rdata[1], m_sef);
    chk({tag, " status LOF"}, reg_rdata[2], m_lof);
    chk({tag, " irq_n"}, irq_n, (m_ist == 0));
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
    if (a == 2'd1) m_ist = 8'h00;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    if (a == 2'd2) m_thr = d[3:0];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    m_sef = 1; m_lof = 1; m_cnt = 0; m_thr = 4; m_ist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_state("R1");
    read_reg(2'd2, d);
    chk("R1 threshold reset", d, 4);
    read_reg(2'd1, d);
    chk("R1 int status reset", d, 0);
    read_reg(2'd3, d);
    chk("R8 address 3 reads zero", d, 0);

    // R7 status pass-through and write ignored
    for (int p = 0; p < 64; p += 7) begin
      los_in = p[0]; aux_defects = p[5:1];
      write_reg(2'd0, 8'hFF);
      reg_addr = 2'd0; #1;
      chk("R7 status map", reg_rdata, {p[5:1], m_lof, m_sef, p[0]});
    end

    for (int t = 0; t < 16; t++) begin
      int need;
      need = (t == 0) ? 1 : t;
      // R8 upper bits dropped
      write_reg(2'd2, 8'hF0 | t[7:0]);
      read_reg(2'd2, d);
      chk("R8 threshold readback", d, t);

      tick(1'b0, 1'b1);
      check_state("R5 loss to hunt");
      read_reg(2'd1, d);
      check_state("R10 irq after clear");

      // R6 no change without tick
      @(negedge clk); in_frame = 1; frame_ok = 1;
      repeat (3) @(negedge clk);
      in_frame = 0;
      check_state("R6 hold without tick");

      tick(1'b1, 1'b1);
      check_state("R2 enter verify");
      read_reg(2'd1, d);
      chk("R9 SEF change flag", d, 8'h02);

      // R4 error one frame short of the run
      for (int k = 0; k < need - 1; k++) tick(1'b1, 1'b1);
      tick(1'b1, 1'b0);
      check_state("R4 error restarts run");

      for (int k = 0; k < need - 1; k++) begin
        tick(1'b1, 1'b1);
        check_state("R3 still LOF");
      end
      tick(1'b1, 1'b1);
      check_state("R3 LOF cleared");
      chk("R3 LOF cleared at N", m_lof, 0);

      tick(1'b1, 1'b0);
      check_state("R5 frame_ok ignored in sync");
      read_reg(2'd1, d);
      chk("R9 LOF change flag", d, 8'h04);
      check_state("R10 irq released");

      if (t == 7 || t == 0) begin
        // R11 event in the same cycle as a clearing read
        @(negedge clk);
        frame_tick = 1; in_frame = 0; frame_ok = 1;
        reg_rd = 1; reg_addr = 2'd1;
        #1 d = reg_rdata;
        chk("R11 read data before event", d, 0);
        @(negedge clk);
        frame_tick = 0; reg_rd = 0;
        model_tick(1'b0, 1'b1, 1'b1);
        check_state("R11 event kept");
        read_reg(2'd1, d);
        chk("R11 both flags pending", d, 8'h06);
        check_state("R10 after read");
      end
    end
    finish_run();
  end

endmodule